// File: doc/BRIEF.md
# Flow-Controlled Receive Buffer Drain Controller

This block sits on the host side of a serial link to a radio receiver. It empties the receiver's frame buffer over a four-wire SPI connection. A single start request carries the number of data bytes wanted. The controller then drops chip select and shifts out a fixed read command byte. After that it pulls data bytes one at a time. Before each byte it looks at a "buffer empty" indicator input: a low level means data is ready and a high level means the transfer must wait.

The indicator is ignored while the command byte is in flight and for a settle window after it. From then on, a high level parks the SPI clock low. If the indicator stays high for longer than two octet periods, the controller gives up. It raises chip select and reports an abort together with the number of bytes it had already read. A normal finish also raises chip select and reports done together with the byte count.

Received bytes leave through a valid/ready stream that holds a single byte. Once `rd_valid` rises, `rd_data` holds still until the consumer takes the byte by asserting `rd_ready` in a clock cycle where `rd_valid` is high. While that byte has not been taken, no further SPI byte is started. A slow consumer therefore holds the serial link back instead of losing data.

Top module: `fbuf_drain_ctrl`

## Requirements
- R1: During and right after reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `rd_valid`, `done` and `abort` are 0.
- R2: A start pulse given while idle drives `spi_cs_n` low and shifts out `CMD_BYTE` (default 8'h20) MSB first in SPI mode 0. In this mode `spi_sclk` idles low, `spi_mosi` changes while the clock is low, and `spi_miso` is sampled on the rising edge. `spi_sclk` never toggles while `spi_cs_n` is high.
- R3: The indicator level is not evaluated during the command byte or during the `SETTLE_CLKS` cycles after it. A high level confined to that window never stalls the transfer and never aborts it, even when it lasts longer than the timeout.
- R4: A data byte begins only after the synchronised indicator has been seen low. While the indicator stays high, `spi_sclk` stays low.
- R5: If the indicator stays high for `2*OCTET_CLKS` consecutive cycles while the controller waits, the read ends. `abort` pulses for one cycle, `spi_cs_n` is high at the same time, and `byte_count` equals the number of bytes already read.
- R6: The stall timer restarts each time the indicator goes low. Many short stalls whose total time is longer than the timeout do not cause an abort.
- R7: Bytes leave on `rd_data` in the order they were received, each taken MSB first from `spi_miso`. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` is stable.
- R8: While an output byte waits to be accepted, no new SPI data byte is started.
- R9: After `start_len` bytes, `done` pulses for one cycle with `spi_cs_n` high and `byte_count` equal to `start_len`. `done` and `abort` are never high together.
- R10: A `start_len` of 0 sends only the command byte and then pulses `done` with `byte_count` equal to 0.
- R11: A start pulse that arrives while a read is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a buffer read; taken only when idle |
| start_len | input | LEN_W | Number of data bytes to read |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the receiver |
| spi_miso | input | 1 | Serial data from the receiver |
| buf_empty_in | input | 1 | Asynchronous buffer-empty indicator, high means not ready |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` holds an unaccepted byte |
| rd_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle pulse on normal completion |
| abort | output | 1 | One-cycle pulse on stall timeout |
| byte_count | output | LEN_W | Bytes read in the current or last read |

## Verification
The last data byte raises `rd_valid` in the same cycle that `done` pulses. The output register and the completion logic therefore act together in that cycle. This is provoked by draining a frame with `rd_ready` held high throughout. It is judged by whether the final byte is collected with the expected value while `done` reports the full count with chip select already high. A second overlap comes from holding the indicator high through the command byte for longer than the timeout. The settle gating and the stall timer could both claim that window, and a correct design completes that read without an abort.

// File: rtl/fbuf_drain_pkg.sv
package fbuf_drain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_SETTLE,
    ST_CHECK,
    ST_XFER,
    ST_STALL,
    ST_DONE,
    ST_ABORT
  } fbuf_state_e;

  // counter width that can hold 0 .. n-1, never narrower than one bit
  function automatic int unsigned fbuf_cw(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/fbuf_sync.sv
module fbuf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fbuf_spi_shift.sv
module fbuf_spi_shift
  import fbuf_drain_pkg::*;
#(
  parameter int HALF_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);

  localparam int DW = fbuf_cw(HALF_CLKS);

  logic [DW-1:0] div_q;
  logic          phase_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q;
  logic [7:0]    rx_q;
  logic          busy_q;
  logic          sclk_q;
  logic          done_q;
  logic          tick;

  assign tick = (div_q == DW'(HALF_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          tx_q    <= tx_byte;
          bit_q   <= '0;
          div_q   <= '0;
          phase_q <= 1'b0;
          sclk_q  <= 1'b0;
        end
      end else if (!tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!phase_q) begin
          sclk_q  <= 1'b1;
          phase_q <= 1'b1;
          rx_q    <= {rx_q[6:0], miso};
        end else begin
          sclk_q  <= 1'b0;
          phase_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

endmodule

// File: rtl/fbuf_stall_timer.sv
module fbuf_stall_timer #(
  parameter int LIMIT = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       run,
  output logic                       expired,
  output logic [$clog2(LIMIT+1)-1:0] count
);

  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear)            cnt_q <= '0;
    else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

endmodule

// File: rtl/fbuf_drain_ctrl.sv
module fbuf_drain_ctrl
  import fbuf_drain_pkg::*;
#(
  parameter int         LEN_W       = 8,
  parameter int         HALF_CLKS   = 2,
  parameter int         OCTET_CLKS  = 32,
  parameter int         SETTLE_CLKS = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CMD_BYTE    = 8'h20,
  parameter logic [7:0] FILL_BYTE   = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  input  logic             buf_empty_in,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             done,
  output logic             abort,
  output logic [LEN_W-1:0] byte_count
);

  localparam int TMO = 2 * OCTET_CLKS;
  localparam int TW  = $clog2(TMO + 1);
  localparam int SW  = fbuf_cw(SETTLE_CLKS);

  fbuf_state_e      state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [SW-1:0]    settle_q;
  logic             empty_s;
  logic             sh_start;
  logic [7:0]       sh_tx;
  logic             sh_busy;
  logic             sh_done;
  logic [7:0]       sh_rx;
  logic             tmo_expired;
  logic [TW-1:0]    stall_cnt;
  logic             out_free;
  logic [7:0]       out_data_q;
  logic             out_valid_q;
  logic             last_byte;

  fbuf_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (buf_empty_in),
    .q     (empty_s)
  );

  fbuf_spi_shift #(
    .HALF_CLKS (HALF_CLKS)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  fbuf_stall_timer #(
    .LIMIT (TMO)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   ((state_q == ST_IDLE) || !empty_s),
    .run     ((state_q == ST_STALL) && empty_s),
    .expired (tmo_expired),
    .count   (stall_cnt)
  );

  assign out_free  = !out_valid_q || rd_ready;
  assign last_byte = ((cnt_q + LEN_W'(1)) == len_q);

  always_comb begin
    state_d  = state_q;
    sh_start = 1'b0;
    sh_tx    = FILL_BYTE;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_CMD;
          sh_start = 1'b1;
          sh_tx    = CMD_BYTE;
        end
      end
      ST_CMD: begin
        if (sh_done) state_d = (len_q == '0) ? ST_DONE : ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settle_q == SW'(SETTLE_CLKS - 1)) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (empty_s) begin
          state_d = ST_STALL;
        end else if (out_free && !sh_busy) begin
          state_d  = ST_XFER;
          sh_start = 1'b1;
        end
      end
      ST_XFER: begin
        if (sh_done) state_d = last_byte ? ST_DONE : ST_CHECK;
      end
      ST_STALL: begin
        if (tmo_expired)   state_d = ST_ABORT;
        else if (!empty_s) state_d = ST_CHECK;
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_ABORT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      len_q    <= '0;
      cnt_q    <= '0;
      settle_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) begin
        len_q <= start_len;
        cnt_q <= '0;
      end
      if (state_q == ST_XFER && sh_done) cnt_q <= cnt_q + 1'b1;
      if (state_q == ST_SETTLE) settle_q <= settle_q + 1'b1;
      else                      settle_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (state_q == ST_XFER && sh_done) begin
      out_valid_q <= 1'b1;
      out_data_q  <= sh_rx;
    end else if (rd_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CMD, ST_SETTLE, ST_CHECK, ST_XFER, ST_STALL: spi_cs_n = 1'b0;
      default:                                        spi_cs_n = 1'b1;
    endcase
  end

  assign rd_data    = out_data_q;
  assign rd_valid   = out_valid_q;
  assign done       = (state_q == ST_DONE);
  assign abort      = (state_q == ST_ABORT);
  assign byte_count = cnt_q;

endmodule

// File: rtl/fbuf_drain_chk.sv
module fbuf_drain_chk
  import fbuf_drain_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int LIMIT = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       sclk,
  input logic [7:0]                 rd_data,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic                       done,
  input logic                       abort,
  input logic [LEN_W-1:0]           byte_count,
  input logic [LEN_W-1:0]           len_q,
  input fbuf_state_e                state_q,
  input logic [$clog2(LIMIT+1)-1:0] stall_cnt
);

  p_clk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_stall_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STALL) |-> !sclk);

  p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt < ($clog2(LIMIT+1))'(LIMIT));

  p_abort_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> cs_n);

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && byte_count == len_q));

  p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && abort));

endmodule

bind fbuf_drain_ctrl fbuf_drain_chk #(
  .LEN_W (LEN_W),
  .LIMIT (2 * OCTET_CLKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (spi_cs_n),
  .sclk       (spi_sclk),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .done       (done),
  .abort      (abort),
  .byte_count (byte_count),
  .len_q      (len_q),
  .state_q    (state_q),
  .stall_cnt  (stall_cnt)
);

// File: tb/fbuf_drain_ctrl_test.sv
`timescale 1ns/1ps
module fbuf_drain_ctrl_test;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] start_len = '0;
  logic             spi_cs_n;
  logic             spi_sclk;
  logic             spi_mosi;
  logic             spi_miso = 1'b0;
  logic             buf_empty_in;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             rd_ready = 1'b1;
  logic             done;
  logic             abort;
  logic [LEN_W-1:0] byte_count;

  int checks = 0;
  int errors = 0;

  // slave and stimulus state
  int         nb = 0;
  logic [7:0] cmd_sh = '0;
  logic [7:0] seed = 8'h5A;
  logic       ind_force = 1'b0;
  int         stall_at = -1;       // -1: none, -2: every byte, k>=1: only after byte k-1
  int         stall_len = 0;
  logic       trig = 1'b0;
  int         hold_left = 0;
  int         hi_run = 0;
  int         r4_viol = 0;
  int         got = 0;

  always #10 clk = ~clk;

  assign buf_empty_in = ind_force || (hold_left > 0);

  fbuf_drain_ctrl #(
    .LEN_W       (LEN_W),
    .HALF_CLKS   (2),
    .OCTET_CLKS  (8),
    .SETTLE_CLKS (4),
    .SYNC_STAGES (2),
    .CMD_BYTE    (8'h20),
    .FILL_BYTE   (8'h00)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_len    (start_len),
    .spi_cs_n     (spi_cs_n),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .spi_miso     (spi_miso),
    .buf_empty_in (buf_empty_in),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .done         (done),
    .abort        (abort),
    .byte_count   (byte_count)
  );

  function automatic logic [7:0] data_of(input logic [7:0] s, input int idx);
    return s ^ 8'(idx * 59);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // receiver model: mode 0
  always @(negedge spi_cs_n) begin
    nb = 0;
    cmd_sh = '0;
  end

  always @(posedge spi_sclk) begin
    if (nb >= 8 && (nb % 8) == 0 && hi_run >= 8) r4_viol++;
    if (nb < 8) cmd_sh = {cmd_sh[6:0], spi_mosi};
    nb++;
    if (nb >= 8 && ((nb - 8) % 8) == 6) begin
      if (stall_at == -2 || (stall_at >= 1 && (nb - 8) / 8 == stall_at - 1)) trig = 1'b1;
    end
  end

  always @(negedge spi_sclk) begin
    if (nb >= 8) begin
      logic [7:0] b;
      b = data_of(seed, (nb - 8) / 8);
      spi_miso = b[7 - (nb % 8)];
    end
  end

  always @(posedge clk) begin
    if (trig) begin
      hold_left = stall_len;
      trig = 1'b0;
    end else if (hold_left > 0) begin
      hold_left = hold_left - 1;
    end
    if (buf_empty_in) hi_run = hi_run + 1;
    else              hi_run = 0;
    if (rst_n && rd_valid && rd_ready) begin
      checks++;
      if (rd_data !== data_of(seed, got)) begin
        errors++;
        $display("FAIL R7: byte %0d actual %0d expected %0d", got, rd_data, data_of(seed, got));
      end
      got++;
    end
  end

  task automatic set_up(input logic [7:0] s, input int sat, input int slen);
    @(negedge clk);
    seed = s;
    stall_at = sat;
    stall_len = slen;
    hold_left = 0;
    ind_force = 1'b0;
    rd_ready = 1'b1;
    got = 0;
    r4_viol = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic kick(input int len);
    @(negedge clk);
    start = 1'b1;
    start_len = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output bit d, output bit a, output int cnt, output bit cs);
    d = 0; a = 0; cnt = 0; cs = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done || abort) begin
        d = done; a = abort; cnt = int'(byte_count); cs = spi_cs_n;
        break;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 cs/sclk in reset", {spi_cs_n, spi_sclk}, 2);
    chk(rd_valid === 1'b0 && done === 1'b0 && abort === 1'b0, "R1 outputs in reset",
        {rd_valid, done, abort}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && !rd_valid, "R1 idle after reset",
        {spi_cs_n, spi_sclk, rd_valid}, 4);
  endtask

  task automatic t_basic();
    bit d, a, cs; int cnt;
    set_up(8'hA5, -1, 0);
    kick(4);
    @(negedge clk);
    chk(spi_cs_n === 1'b0, "R2 cs low after start", spi_cs_n, 0);
    wait_end(d, a, cnt, cs);
    chk(cmd_sh == 8'h20, "R2 command byte", cmd_sh, 32);
    chk(d && !a, "R9 done without abort", {d, a}, 2);
    chk(cnt == 4 && cs, "R9 count and cs at done", cnt, 4);
    chk(got == 4, "R7 bytes delivered", got, 4);
  endtask

  task automatic t_cmd_window();
    bit d, a, cs; int cnt;
    set_up(8'h3C, -1, 0);
    ind_force = 1'b1;
    kick(3);
    repeat (28) @(negedge clk);
    ind_force = 1'b0;
    wait_end(d, a, cnt, cs);
    chk(d && !a, "R3 high during command ignored", {d, a}, 2);
    chk(cnt == 3 && got == 3, "R3 all bytes read", got, 3);
  endtask

  task automatic t_short_stalls();
    bit d, a, cs; int cnt;
    set_up(8'h71, -2, 20);
    kick(5);
    wait_end(d, a, cnt, cs);
    chk(d && !a, "R6 repeated short stalls no abort", {d, a}, 2);
    chk(cnt == 5 && got == 5, "R6 all bytes read", got, 5);
    chk(r4_viol == 0, "R4 no byte start while indicator high", r4_viol, 0);
  endtask

  task automatic t_timeout();
    bit d, a, cs; int cnt;
    set_up(8'hC3, 2, 1000000);
    kick(4);
    wait_end(d, a, cnt, cs);
    chk(a && !d, "R5 abort on long stall", {d, a}, 1);
    chk(cnt == 2, "R5 abort count", cnt, 2);
    chk(cs, "R5 cs high at abort", cs, 1);
    chk(got == 2 && r4_viol == 0, "R4 bytes before stall only", got, 2);
    hold_left = 0;
  endtask

  task automatic t_backpressure();
    bit d, a, cs; int cnt;
    logic [7:0] first;
    set_up(8'h19, -1, 0);
    rd_ready = 1'b0;
    kick(3);
    for (int i = 0; i < 400 && !rd_valid; i++) @(negedge clk);
    first = rd_data;
    repeat (60) @(negedge clk);
    chk(rd_valid && rd_data == first, "R7 valid held and data stable", rd_data, first);
    chk(nb == 16, "R8 no new byte while output full", nb, 16);
    rd_ready = 1'b1;
    wait_end(d, a, cnt, cs);
    chk(d && cnt == 3 && got == 3, "R8 completes after release", got, 3);
  endtask

  task automatic t_zero_len();
    bit d, a, cs; int cnt;
    set_up(8'h66, -1, 0);
    kick(0);
    wait_end(d, a, cnt, cs);
    chk(d && cnt == 0 && cs, "R10 zero length done", cnt, 0);
    chk(nb == 8 && got == 0, "R10 only command clocked", nb, 8);
  endtask

  task automatic t_busy_start();
    bit d, a, cs; int cnt;
    set_up(8'h0F, -1, 0);
    kick(3);
    repeat (20) @(negedge clk);
    kick(7);
    wait_end(d, a, cnt, cs);
    chk(d && cnt == 3 && got == 3, "R11 start while busy ignored", cnt, 3);
    repeat (10) @(negedge clk);
    chk(spi_cs_n === 1'b1 && got == 3, "R11 no second read", got, 3);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_cmd_window();
    t_short_stalls();
    t_timeout();
    t_backpressure();
    t_zero_len();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule